// File: doc/BRIEF.md
# Atomic Scalar Read-Modify-Write Unit

This unit sits beside a memory controller and performs indivisible read-modify-write operations on single 64-bit words. A requester hands it a command carrying an opcode, a word address, an operand, a comparison value, a flag asking for a reply and a tag. The unit reads the word, combines it with the operand, writes the result back, and can return the word's previous value, labelled with the tag, so the requester can file the reply in the right place.

One opcode is a counting increment for barriers. It adds one to the stored word, returns the value from before the increment, and compares the incremented value with the supplied comparison value. When they are equal, the unit raises a notification carrying the address and the new value, which the coherence logic uses to push the word out to every holder of a copy. Several commands may wait on memory at once. A command aimed at a word that still has an operation in progress is held back until that operation has written its result.

Top module: `amo_scalar_unit`

## Requirements
- R1: After reset, cmdReady is 1 and memWrEn, rspValid and updValid are 0.
- R2: Each accepted command raises memRdEn with memRdAddr equal to cmdAddr in the cycle it is accepted. Memory returns read data in issue order. One cycle after memRdDataValid, memWrEn writes the updated word to the same address.
- R3: Opcode 0 (swap) stores the operand and returns the word's previous value.
- R4: Opcode 1 stores old plus operand and opcode 2 stores old minus operand. Both wrap modulo 2^width.
- R5: Opcode 3 stores the low half of old times operand.
- R6: With cmdWide 0, the operation uses bits 31:0 only. Bits 63:32 of the stored word are kept. The returned value is the old low half, zero-extended. With cmdWide 1, all 64 bits take part.
- R7: A response with cmdRet 1 appears on rspValid in the same cycle as its write, carrying the command's tag and the old value. With cmdRet 0 no response is produced.
- R8: Opcode 4 (barrier increment) stores old plus 1 and returns old. When the incremented value (its low half in 32-bit mode) equals cmdTest, updValid pulses in the write cycle with updAddr and updData set to the address and the new word. Otherwise no notification is produced.
- R9: Up to DEPTH commands may be outstanding between acceptance and read data. With DEPTH outstanding, cmdReady is 0.
- R10: A command whose address matches an outstanding or writing operation sees cmdReady 0 until that write has been issued. Back-to-back updates to one word therefore accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command accepted this cycle when valid |
| cmdOp | input | 3 | Opcode: 0 swap, 1 add, 2 subtract, 3 multiply, 4 barrier increment |
| cmdWide | input | 1 | 1 for 64-bit, 0 for 32-bit operation |
| cmdRet | input | 1 | Return old value when 1 |
| cmdTag | input | TAG_W | Requester tag |
| cmdAddr | input | ADDR_W | Word address |
| cmdOperand | input | DATA_W | Operand |
| cmdTest | input | DATA_W | Comparison value for barrier increment |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | ADDR_W | Read address |
| memRdDataValid | input | 1 | Read data returned (issue order) |
| memRdData | input | DATA_W | Read data |
| memWrEn | output | 1 | Memory write |
| memWrAddr | output | ADDR_W | Write address |
| memWrData | output | DATA_W | Write data |
| rspValid | output | 1 | Response present |
| rspTag | output | TAG_W | Response tag |
| rspData | output | DATA_W | Old value of the word |
| updValid | output | 1 | Barrier-match notification |
| updAddr | output | ADDR_W | Address of the matched word |
| updData | output | DATA_W | New value of the matched word |

## Verification
Each opcode is applied to stored words chosen so that a wrong operation shows up as a wrong value. Swap is given a value unlike the old one. Add is given an all-ones word so that it wraps, and subtract is made to underflow. Multiply is given factors whose product overflows 64 bits. The same add is repeated in 32-bit mode on a word with nonzero upper bits, which shows whether the width selection and the preservation of the upper half are right. The barrier increment is run once with a matching comparison value and once with a value that is off by one, which separates a correct match from a notification raised on every increment. Four commands to distinct words are issued back to back to fill every slot, and two adds to one word are issued back to back, so that a missing hold shows up as a lost update.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    OP_SWAP = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_MUL  = 3'd3,
    OP_BINC = 3'd4
  } amo_op_e;

  typedef struct packed {
    logic accept;
    logic retire;
  } amo_strobe_t;
endpackage

// File: rtl/amo_ctrl.sv
module amo_ctrl #(
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 addrHit,
  input  logic                 memRdDataValid,
  output logic                 cmdReady,
  output amo_pkg::amo_strobe_t strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] inFlight;

  assign cmdReady      = (inFlight < CNT_W'(DEPTH)) && !addrHit;
  assign strobe.accept = cmdValid && cmdReady;
  assign strobe.retire = memRdDataValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= '0;
    end else begin
      case ({strobe.accept, strobe.retire})
        2'b10:   inFlight <= inFlight + 1'b1;
        2'b01:   inFlight <= inFlight - 1'b1;
        default: inFlight <= inFlight;
      endcase
    end
  end
endmodule

// File: rtl/amo_datapath.sv
module amo_datapath #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  amo_pkg::amo_strobe_t strobe,
  input  logic [2:0]           cmdOp,
  input  logic                 cmdWide,
  input  logic                 cmdRet,
  input  logic [TAG_W-1:0]     cmdTag,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [DATA_W-1:0]    cmdOperand,
  input  logic [DATA_W-1:0]    cmdTest,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 addrHit,
  output logic                 memWrEn,
  output logic [ADDR_W-1:0]    memWrAddr,
  output logic [DATA_W-1:0]    memWrData,
  output logic                 rspValid,
  output logic [TAG_W-1:0]     rspTag,
  output logic [DATA_W-1:0]    rspData,
  output logic                 updValid
);
  import amo_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int HALF  = DATA_W / 2;

  logic [2:0]        slotOp   [DEPTH];
  logic              slotWide [DEPTH];
  logic              slotRet  [DEPTH];
  logic [TAG_W-1:0]  slotTag  [DEPTH];
  logic [ADDR_W-1:0] slotAddr [DEPTH];
  logic [DATA_W-1:0] slotOpnd [DEPTH];
  logic [DATA_W-1:0] slotTest [DEPTH];
  logic [DEPTH-1:0]  slotVld;
  logic [DEPTH-1:0]  slotMatch;
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  // Address hazard compare, one comparator per slot plus the write stage
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign slotMatch[i] = slotVld[i] && (slotAddr[i] == cmdAddr);
  end
  assign addrHit = (|slotMatch) || (memWrEn && (memWrAddr == cmdAddr));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotVld <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
    end else begin
      if (strobe.accept) begin
        slotVld[wrPtr]  <= 1'b1;
        slotOp[wrPtr]   <= cmdOp;
        slotWide[wrPtr] <= cmdWide;
        slotRet[wrPtr]  <= cmdRet;
        slotTag[wrPtr]  <= cmdTag;
        slotAddr[wrPtr] <= cmdAddr;
        slotOpnd[wrPtr] <= cmdOperand;
        slotTest[wrPtr] <= cmdTest;
        wrPtr           <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (strobe.retire) begin
        slotVld[rdPtr] <= 1'b0;
        rdPtr          <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
    end
  end

  // Operation on the head slot with the returned word
  logic [DATA_W-1:0] oldVal, opndVal, aluRes, newWord, retVal;
  logic              testHit;

  always_comb begin
    oldVal  = slotWide[rdPtr] ? memRdData : {{HALF{1'b0}}, memRdData[HALF-1:0]};
    opndVal = slotWide[rdPtr] ? slotOpnd[rdPtr]
                              : {{HALF{1'b0}}, slotOpnd[rdPtr][HALF-1:0]};
    case (amo_op_e'(slotOp[rdPtr]))
      OP_SWAP: aluRes = opndVal;
      OP_ADD:  aluRes = oldVal + opndVal;
      OP_SUB:  aluRes = oldVal - opndVal;
      OP_MUL:  aluRes = oldVal * opndVal;
      OP_BINC: aluRes = oldVal + DATA_W'(1);
      default: aluRes = oldVal;
    endcase
    newWord = slotWide[rdPtr] ? aluRes : {memRdData[DATA_W-1:HALF], aluRes[HALF-1:0]};
    retVal  = oldVal;
    testHit = (slotOp[rdPtr] == OP_BINC) &&
              (slotWide[rdPtr] ? (aluRes == slotTest[rdPtr])
                               : (aluRes[HALF-1:0] == slotTest[rdPtr][HALF-1:0]));
  end

  // Write-back stage: memory write, response and notification leave together
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn  <= 1'b0;
      rspValid <= 1'b0;
      updValid <= 1'b0;
    end else begin
      memWrEn  <= strobe.retire;
      rspValid <= strobe.retire && slotRet[rdPtr];
      updValid <= strobe.retire && testHit;
    end
    if (strobe.retire) begin
      memWrAddr <= slotAddr[rdPtr];
      memWrData <= newWord;
      rspTag    <= slotTag[rdPtr];
      rspData   <= retVal;
    end
  end
endmodule

// File: rtl/amo_scalar_unit.sv
module amo_scalar_unit #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic              cmdWide,
  input  logic              cmdRet,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdOperand,
  input  logic [DATA_W-1:0] cmdTest,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdDataValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic [DATA_W-1:0] rspData,
  output logic              updValid,
  output logic [ADDR_W-1:0] updAddr,
  output logic [DATA_W-1:0] updData
);
  amo_pkg::amo_strobe_t strobe;
  logic                 addrHit;

  amo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cmdValid       (cmdValid),
    .addrHit        (addrHit),
    .memRdDataValid (memRdDataValid),
    .cmdReady       (cmdReady),
    .strobe         (strobe)
  );

  amo_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdOp      (cmdOp),
    .cmdWide    (cmdWide),
    .cmdRet     (cmdRet),
    .cmdTag     (cmdTag),
    .cmdAddr    (cmdAddr),
    .cmdOperand (cmdOperand),
    .cmdTest    (cmdTest),
    .memRdData  (memRdData),
    .addrHit    (addrHit),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .rspValid   (rspValid),
    .rspTag     (rspTag),
    .rspData    (rspData),
    .updValid   (updValid)
  );

  assign memRdEn   = strobe.accept;
  assign memRdAddr = cmdAddr;
  assign updAddr   = memWrAddr;
  assign updData   = memWrData;
endmodule

// File: rtl/amo_scalar_unit_chk.sv
module amo_scalar_unit_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memRdDataValid,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              rspValid,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic [DATA_W-1:0] updData
);
  localparam int CNT_W = $clog2(DEPTH + 2);
  logic [CNT_W-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else       pend <= pend + CNT_W'(memRdEn) - CNT_W'(memRdDataValid);
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!memWrEn && !rspValid && !updValid));

  a_r2_read_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (cmdValid && cmdReady));

  a_r2_write_follows_data: assert property (@(posedge clk) disable iff (!rstN)
    memRdDataValid |=> memWrEn);

  a_r2_write_only_after_data: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(memRdDataValid));

  a_r7_rsp_with_write: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> memWrEn);

  a_r8_upd_matches_write: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> (memWrEn && updAddr == memWrAddr && updData == memWrData));

  a_r9_depth_limit: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (pend < CNT_W'(DEPTH)));

  a_r10_no_read_of_writing_word: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && memWrEn) |-> (memRdAddr != memWrAddr));
endmodule

bind amo_scalar_unit amo_scalar_unit_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .cmdValid       (cmdValid),
  .cmdReady       (cmdReady),
  .memRdEn        (memRdEn),
  .memRdAddr      (memRdAddr),
  .memRdDataValid (memRdDataValid),
  .memWrEn        (memWrEn),
  .memWrAddr      (memWrAddr),
  .memWrData      (memWrData),
  .rspValid       (rspValid),
  .updValid       (updValid),
  .updAddr        (updAddr),
  .updData        (updData)
);

// File: tb/amo_scalar_unit_bench.sv
module amo_scalar_unit_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 4;
  localparam int LAT    = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [2:0]        cmdOp = '0;
  logic              cmdWide = 1'b1;
  logic              cmdRet = 1'b1;
  logic [TAG_W-1:0]  cmdTag = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [DATA_W-1:0] cmdOperand = '0;
  logic [DATA_W-1:0] cmdTest = '0;
  logic              memRdEn;
  logic [ADDR_W-1:0] memRdAddr;
  logic              memRdDataValid;
  logic [DATA_W-1:0] memRdData;
  logic              memWrEn;
  logic [ADDR_W-1:0] memWrAddr;
  logic [DATA_W-1:0] memWrData;
  logic              rspValid;
  logic [TAG_W-1:0]  rspTag;
  logic [DATA_W-1:0] rspData;
  logic              updValid;
  logic [ADDR_W-1:0] updAddr;
  logic [DATA_W-1:0] updData;

  always #5 clk = ~clk;

  amo_scalar_unit u_amo_scalar_unit (.*);

  // Memory model with fixed latency, in-order returns
  logic [DATA_W-1:0] mem [16];
  logic              pv [LAT];
  logic [DATA_W-1:0] pd [LAT];
  logic              pokeEn = 1'b0;
  logic [3:0]        pokeAddr = '0;
  logic [DATA_W-1:0] pokeData = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
    end else begin
      pv[0] <= memRdEn;
      pd[0] <= mem[memRdAddr[3:0]];
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
    end
    if (memWrEn) mem[memWrAddr[3:0]] <= memWrData;
    if (pokeEn)  mem[pokeAddr] <= pokeData;
  end
  assign memRdDataValid = pv[LAT-1];
  assign memRdData      = pd[LAT-1];

  // Output logs
  logic [DATA_W-1:0] rspLogD [64];
  logic [TAG_W-1:0]  rspLogT [64];
  logic [DATA_W-1:0] updLogD [64];
  logic [ADDR_W-1:0] updLogA [64];
  int rspN = 0, updN = 0;
  always @(negedge clk) begin
    if (rspValid) begin rspLogD[rspN] = rspData; rspLogT[rspN] = rspTag; rspN++; end
    if (updValid) begin updLogD[updN] = updData; updLogA[updN] = updAddr; updN++; end
  end

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [63:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = 4'(a); pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic send(input logic [2:0] op, input bit wide, input bit ret, input int tag,
                      input int addr, input logic [63:0] opnd, input logic [63:0] tst);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdWide = wide; cmdRet = ret; cmdTag = TAG_W'(tag);
    cmdAddr = ADDR_W'(addr); cmdOperand = opnd; cmdTest = tst;
    #1;
    while (!cmdReady) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idleWait(input int n);
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    check(cmdReady == 1'b1, "R1 cmdReady", 64'(cmdReady), 64'd1);
    check(!memWrEn && !rspValid && !updValid, "R1 outputs idle",
          {61'd0, memWrEn, rspValid, updValid}, 64'd0);
  endtask

  task automatic t_swap;
    int r0;
    poke(1, 64'h1111_2222_3333_4444);
    r0 = rspN;
    send(3'd0, 1, 1, 5, 1, 64'hDEAD_BEEF_0000_0001, 0);
    idleWait(12);
    check(mem[1] == 64'hDEAD_BEEF_0000_0001, "R3 swap store", mem[1], 64'hDEAD_BEEF_0000_0001);
    check(rspLogD[r0] == 64'h1111_2222_3333_4444, "R3 swap old", rspLogD[r0], 64'h1111_2222_3333_4444);
    check(rspLogT[r0] == 4'd5, "R7 tag", 64'(rspLogT[r0]), 64'd5);
    check(rspN == r0 + 1, "R2 one response", 64'(rspN - r0), 64'd1);
  endtask

  task automatic t_addsub;
    poke(2, 64'hFFFF_FFFF_FFFF_FFFF);
    poke(3, 64'd5);
    send(3'd1, 1, 1, 1, 2, 64'd2, 0);
    send(3'd2, 1, 1, 2, 3, 64'd7, 0);
    idleWait(14);
    check(mem[2] == 64'd1, "R4 add wrap", mem[2], 64'd1);
    check(mem[3] == 64'hFFFF_FFFF_FFFF_FFFE, "R4 sub wrap", mem[3], 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_mul;
    logic [63:0] a, b, e;
    a = 64'h1_0000_0003; b = 64'h2_0000_0005; e = a * b;
    poke(4, a);
    send(3'd3, 1, 1, 3, 4, b, 0);
    idleWait(12);
    check(mem[4] == e, "R5 mul low half", mem[4], e);
  endtask

  task automatic t_narrow;
    int r0;
    poke(5, 64'hABCD_0123_FFFF_FFFE);
    r0 = rspN;
    send(3'd1, 0, 1, 6, 5, 64'h7777_7777_0000_0003, 0);
    idleWait(12);
    check(mem[5] == 64'hABCD_0123_0000_0001, "R6 narrow add", mem[5], 64'hABCD_0123_0000_0001);
    check(rspLogD[r0] == 64'h0000_0000_FFFF_FFFE, "R6 narrow return", rspLogD[r0], 64'h0000_0000_FFFF_FFFE);
  endtask

  task automatic t_noret;
    int r0;
    poke(6, 64'd10);
    r0 = rspN;
    send(3'd1, 1, 0, 7, 6, 64'd1, 0);
    idleWait(12);
    check(rspN == r0, "R7 no response", 64'(rspN - r0), 64'd0);
    check(mem[6] == 64'd11, "R7 write still done", mem[6], 64'd11);
  endtask

  task automatic t_barrier;
    int r0, u0;
    poke(7, 64'd6);
    r0 = rspN; u0 = updN;
    send(3'd4, 1, 1, 8, 7, 0, 64'd7);
    idleWait(12);
    check(rspLogD[r0] == 64'd6, "R8 barrier old", rspLogD[r0], 64'd6);
    check(mem[7] == 64'd7, "R8 barrier store", mem[7], 64'd7);
    check(updN == u0 + 1, "R8 update on match", 64'(updN - u0), 64'd1);
    check(updLogD[u0] == 64'd7 && updLogA[u0] == 16'd7, "R8 update payload", updLogD[u0], 64'd7);
    u0 = updN;
    send(3'd4, 1, 1, 9, 7, 0, 64'd9);
    idleWait(12);
    check(updN == u0, "R8 no update on mismatch", 64'(updN - u0), 64'd0);
  endtask

  task automatic t_outstanding;
    for (int i = 0; i < 4; i++) poke(8 + i, 64'(100 * i));
    send(3'd1, 1, 1, 0, 8, 64'd1, 0);
    send(3'd1, 1, 1, 1, 9, 64'd1, 0);
    send(3'd1, 1, 1, 2, 10, 64'd1, 0);
    send(3'd1, 1, 1, 3, 11, 64'd1, 0);
    @(negedge clk);
    cmdAddr = 16'd12; cmdOp = 3'd1;
    #1;
    check(cmdReady == 1'b0, "R9 full holds ready low", 64'(cmdReady), 64'd0);
    idleWait(14);
    for (int i = 0; i < 4; i++)
      check(mem[8 + i] == 64'(100 * i + 1), "R9 all slots retire", mem[8 + i], 64'(100 * i + 1));
  endtask

  task automatic t_hazard;
    int r0;
    poke(13, 64'd40);
    r0 = rspN;
    send(3'd1, 1, 1, 1, 13, 64'd2, 0);
    @(negedge clk);
    cmdOperand = 64'd5; cmdTag = 4'd2;
    #1;
    check(cmdReady == 1'b0, "R10 hold same address", 64'(cmdReady), 64'd0);
    while (!cmdReady) begin @(negedge clk); #1; end
    @(posedge clk);
    idleWait(14);
    check(mem[13] == 64'd47, "R10 updates accumulate", mem[13], 64'd47);
    check(rspLogD[r0 + 1] == 64'd42, "R10 second sees first", rspLogD[r0 + 1], 64'd42);
  endtask

  bit done = 1'b0;
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_swap();
    t_addsub();
    t_mul();
    t_narrow();
    t_noret();
    t_barrier();
    t_outstanding();
    t_hazard();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule